// File: doc/BRIEF.md
# Filtered Event Counter with Sticky Overflow

This block is a single programmable 64-bit event counter. An upstream event mapper pulses `inc_i` when the selected event occurs. The counter steps by one on that pulse only when three conditions hold. The per-counter halt bit must be clear. The inhibit bit that belongs to the current privilege level and virtualization state must be clear. Software must not be writing the counter or its selector in the same cycle.

When the count steps from all ones it wraps to zero. The wrap sets a sticky overflow flag. If the flag was clear beforehand, the wrap also produces a one-cycle overflow interrupt request.

Software accesses the block in one of two layouts. In wide mode the counter and the selector are each written as one 64-bit word. In narrow mode they are written as two 32-bit halves. In narrow mode the overflow flag and the inhibit bits sit in the top bits of the selector's upper half.

Top module: `pcnt_filtered_counter`

## Requirements
- R1: While reset is held and after it is released, the count is zero, every selector bit reads zero and `irq_o` is low.
- R2: The count rises by exactly one per clock edge when all of these hold: `inc_i` is high, `halt_i` is low, the active inhibit bit is clear, and no write takes effect in that cycle.
- R3: While `halt_i` is high, `inc_i` leaves the count unchanged.
- R4: Privilege encoding on `priv_i` is 0=user, 1=supervisor, 3=machine and 2=reserved. Selector bit 62 blocks counting in machine mode whatever `virt_i` is. Bit 61 blocks counting in supervisor mode and bit 60 blocks counting in user mode, each only while `virt_i` is low. Code 2 is never blocked.
- R5: While `virt_i` is high, supervisor mode is blocked by selector bit 59 and user mode by bit 58. Bits 61 and 60 then have no effect.
- R6: A step carries from the low 32-bit half into the high half in the same cycle. A step from all ones gives zero.
- R7: A wrap with the overflow flag (selector bit 63) clear sets the flag and drives `irq_o` high for exactly the following cycle. A wrap with the flag already set leaves `irq_o` low.
- R8: Once set, the overflow flag stays set until software writes it to zero.
- R9: When `narrow_i` is low, `cnt_we_i[0]` loads all 64 bits of `wdata_i` into the count. `sel_we_i[0]` loads bits 63..58 of `wdata_i` into the selector. `cnt_we_i[1]` and `sel_we_i[1]` have no effect.
- R10: When `narrow_i` is high, `cnt_we_i[0]` loads `wdata_i[31:0]` into the low half of the count and `cnt_we_i[1]` loads it into the high half. `sel_we_i[1]` loads `wdata_i[31:26]` into selector bits 63..58. `sel_we_i[0]` has no effect. A wrap still needs all 64 bits at one.
- R11: A counter or selector write that takes effect cancels a step in the same cycle. The written value is what appears afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| inc_i | input | 1 | Event pulse from the event mapper |
| halt_i | input | 1 | This counter's halt bit from the shared halt register |
| priv_i | input | 2 | Current privilege level |
| virt_i | input | 1 | Virtualized execution active |
| narrow_i | input | 1 | Software access in 32-bit halves |
| cnt_we_i | input | 2 | Counter write strobes, one per half |
| sel_we_i | input | 2 | Selector write strobes, one per half |
| wdata_i | input | 64 | Software write data |
| cnt_o | output | 64 | Current count |
| sel_o | output | 64 | Selector readback: flag at bit 63, inhibit bits at 62..58, other bits zero |
| irq_o | output | 1 | One-cycle overflow interrupt request |

## Verification
The inhibit logic is tried with every privilege code, with and without virtualization, and with each inhibit bit set alone. This shows whether the virtualized and plain bits are kept apart and whether machine mode ignores `virt_i`.

Counter values loaded just below the half boundary and at all ones separate a missing carry from a wrong wrap. A second wrap with the flag still set tells a sticky, edge-only interrupt from a level one.

Writes in both layouts, some issued in the same cycle as an event, show which strobe reaches which bits and that the write wins. A long random run with a fixed seed mixes all of these against a bench model.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

  typedef enum logic [1:0] {
    LVL_USER  = 2'd0,
    LVL_SUPV  = 2'd1,
    LVL_RSVD  = 2'd2,
    LVL_MACH  = 2'd3
  } lvl_e;

  // Stored selector bits, most significant first: they occupy the top of the selector word
  typedef struct packed {
    logic ovf;
    logic m_blk;
    logic s_blk;
    logic u_blk;
    logic vs_blk;
    logic vu_blk;
  } evsel_t;

  localparam int unsigned EVSEL_W = $bits(evsel_t);

endpackage

// File: rtl/pcnt_rst_sync.sv
module pcnt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/pcnt_filter.sv
module pcnt_filter
  import pcnt_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic       virt_i,
  input  evsel_t     sel_i,
  output logic       allow_o
);

  logic blocked;

  always_comb begin
    blocked = 1'b0;
    unique case (lvl_e'(priv_i))
      LVL_MACH: blocked = sel_i.m_blk;
      LVL_SUPV: blocked = virt_i ? sel_i.vs_blk : sel_i.s_blk;
      LVL_USER: blocked = virt_i ? sel_i.vu_blk : sel_i.u_blk;
      default:  blocked = 1'b0;
    endcase
  end

  assign allow_o = ~blocked;

endmodule

// File: rtl/pcnt_chain.sv
module pcnt_chain #(
  parameter int unsigned CW = 64,
  parameter int unsigned HW = CW / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          narrow_i,
  input  logic [1:0]    we_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);

  localparam int unsigned NH = CW / HW;

  logic [NH-1:0][HW-1:0] half_q;
  logic [NH-1:0][HW-1:0] half_d;
  logic [NH-1:0]         carry_in;
  logic [NH-1:0]         half_we;
  logic [NH-1:0]         half_en;

  for (genvar h = 0; h < NH; h++) begin : g_half
    logic [HW-1:0] wval;

    if (h == 0) begin : g_first
      assign carry_in[h] = step_i;
    end else begin : g_rest
      assign carry_in[h] = carry_in[h-1] & (&half_q[h-1]);
    end

    always_comb begin
      half_we[h] = narrow_i ? we_i[h % 2] : we_i[0];
      wval       = narrow_i ? wdata_i[HW-1:0] : wdata_i[h*HW +: HW];
      half_en[h] = half_we[h] | carry_in[h];
      if (half_we[h]) begin
        half_d[h] = wval;
      end else begin
        half_d[h] = half_q[h] + {{(HW-1){1'b0}}, 1'b1};
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        half_q[h] <= '0;
      end else if (half_en[h]) begin
        half_q[h] <= half_d[h];
      end
    end
  end

  assign cnt_o  = half_q;
  assign wrap_o = carry_in[NH-1] & (&half_q[NH-1]);

endmodule

// File: rtl/pcnt_filtered_counter.sv
module pcnt_filtered_counter
  import pcnt_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             halt_i,
  input  logic [1:0]       priv_i,
  input  logic             virt_i,
  input  logic             narrow_i,
  input  logic [1:0]       cnt_we_i,
  input  logic [1:0]       sel_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] sel_o,
  output logic             irq_o
);

  localparam int unsigned HALF_W = CNT_W / 2;

  logic   rst_n_q;
  evsel_t sel_q, sel_d, sel_wval;
  logic   sel_wr, sel_en, cnt_wr;
  logic   allow, step, wrap;
  logic   irq_q, irq_d;

  pcnt_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_q)
  );

  pcnt_filter u_filter (
    .priv_i  (priv_i),
    .virt_i  (virt_i),
    .sel_i   (sel_q),
    .allow_o (allow)
  );

  always_comb begin
    sel_wr   = narrow_i ? sel_we_i[1] : sel_we_i[0];
    cnt_wr   = narrow_i ? (|cnt_we_i) : cnt_we_i[0];
    sel_wval = narrow_i ? evsel_t'(wdata_i[HALF_W-1 -: EVSEL_W])
                        : evsel_t'(wdata_i[CNT_W-1 -: EVSEL_W]);
    step     = inc_i & ~halt_i & allow & ~cnt_wr & ~sel_wr;
  end

  pcnt_chain #(.CW(CNT_W), .HW(HALF_W)) u_chain (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_q),
    .step_i   (step),
    .narrow_i (narrow_i),
    .we_i     (cnt_we_i),
    .wdata_i  (wdata_i),
    .cnt_o    (cnt_o),
    .wrap_o   (wrap)
  );

  always_comb begin
    sel_d  = sel_q;
    sel_en = sel_wr | wrap;
    irq_d  = wrap & ~sel_q.ovf;
    if (sel_wr) begin
      sel_d = sel_wval;
    end else if (wrap) begin
      sel_d.ovf = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_q) begin
    if (!rst_n_q) begin
      sel_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      if (sel_en) begin
        sel_q <= sel_d;
      end
    end
  end

  assign sel_o = {sel_q, {(CNT_W-EVSEL_W){1'b0}}};
  assign irq_o = irq_q;

endmodule

// File: rtl/pcnt_filtered_counter_chk.sv
module pcnt_filtered_counter_chk #(
  parameter int unsigned CNT_W = 64
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             step,
  input logic             halt_i,
  input logic             narrow_i,
  input logic [1:0]       cnt_we_i,
  input logic [1:0]       sel_we_i,
  input logic [CNT_W-1:0] wdata_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic [CNT_W-1:0] sel_o,
  input logic             irq_o
);

  a_r3_halt_holds: assert property (@(posedge clk_i) disable iff (!rst_n)
    (halt_i && cnt_we_i == 2'b00) |=> $stable(cnt_o));

  a_r2_step_adds_one: assert property (@(posedge clk_i) disable iff (!rst_n)
    (step && cnt_o != '1) |=> (cnt_o == $past(cnt_o) + 1'b1));

  a_r6_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_n)
    (step && cnt_o == '1) |=> (cnt_o == '0));

  a_r7_irq_with_flag: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o |-> sel_o[CNT_W-1]);

  a_r7_irq_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o |=> !irq_o);

  a_r8_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_n)
    (sel_o[CNT_W-1] && !(narrow_i ? sel_we_i[1] : sel_we_i[0])) |=> sel_o[CNT_W-1]);

  a_r11_write_wins: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!narrow_i && cnt_we_i[0]) |=> (cnt_o == $past(wdata_i)));

endmodule

bind pcnt_filtered_counter pcnt_filtered_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_n    (rst_n_q),
  .step     (step),
  .halt_i   (halt_i),
  .narrow_i (narrow_i),
  .cnt_we_i (cnt_we_i),
  .sel_we_i (sel_we_i),
  .wdata_i  (wdata_i),
  .cnt_o    (cnt_o),
  .sel_o    (sel_o),
  .irq_o    (irq_o)
);

// File: tb/pcnt_filtered_counter_test.sv
`timescale 1ns/1ps
module pcnt_filtered_counter_test;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        inc_i, halt_i, virt_i, narrow_i;
  logic [1:0]  priv_i, cnt_we_i, sel_we_i;
  logic [63:0] wdata_i;
  logic [63:0] cnt_o, sel_o;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [63:0] m_cnt;
  logic [5:0]  m_sel;
  logic        m_irq;

  always #10 clk = ~clk;

  pcnt_filtered_counter uut (
    .clk_i(clk), .rst_ni(rst_ni), .inc_i(inc_i), .halt_i(halt_i),
    .priv_i(priv_i), .virt_i(virt_i), .narrow_i(narrow_i),
    .cnt_we_i(cnt_we_i), .sel_we_i(sel_we_i), .wdata_i(wdata_i),
    .cnt_o(cnt_o), .sel_o(sel_o), .irq_o(irq_o)
  );

  // Selector model bits: [5]=flag [4]=M [3]=S [2]=U [1]=VS [0]=VU
  function automatic bit blocked(logic [1:0] p, logic v, logic [5:0] s);
    case (p)
      2'd3:    return s[4];
      2'd1:    return v ? s[1] : s[3];
      2'd0:    return v ? s[0] : s[2];
      default: return 1'b0;
    endcase
  endfunction

  task automatic set_in(logic inc, logic halt, logic [1:0] p, logic v, logic nar,
                        logic [1:0] cwe, logic [1:0] swe, logic [63:0] wd);
    inc_i = inc; halt_i = halt; priv_i = p; virt_i = v; narrow_i = nar;
    cnt_we_i = cwe; sel_we_i = swe; wdata_i = wd;
  endtask

  task automatic compare(string req);
    checks++;
    if (cnt_o !== m_cnt || sel_o !== {m_sel, 58'b0} || irq_o !== m_irq) begin
      fails++;
      $display("FAIL %s cnt=%h exp=%h sel=%h exp=%h irq=%b exp=%b",
               req, cnt_o, m_cnt, sel_o, {m_sel, 58'b0}, irq_o, m_irq);
    end
  endtask

  task automatic cycle_chk(string req);
    logic [1:0]  cw;
    logic        sw;
    logic [63:0] nc;
    logic [5:0]  ns;
    logic        ni;
    cw = narrow_i ? cnt_we_i : {1'b0, cnt_we_i[0]};
    sw = narrow_i ? sel_we_i[1] : sel_we_i[0];
    nc = m_cnt; ns = m_sel; ni = 1'b0;
    if (cw != 2'b00 || sw) begin
      if (!narrow_i && cw[0]) nc = wdata_i;
      if (narrow_i && cw[0])  nc[31:0]  = wdata_i[31:0];
      if (narrow_i && cw[1])  nc[63:32] = wdata_i[31:0];
      if (sw) ns = narrow_i ? wdata_i[31:26] : wdata_i[63:58];
    end else if (inc_i && !halt_i && !blocked(priv_i, virt_i, m_sel)) begin
      if (&m_cnt) begin
        nc = '0; ni = ~m_sel[5]; ns[5] = 1'b1;
      end else begin
        nc = m_cnt + 64'd1;
      end
    end
    @(posedge clk);
    #2;
    m_cnt = nc; m_sel = ns; m_irq = ni;
    compare(req);
  endtask

  task automatic idle();
    set_in(0, 0, 2'd3, 0, 0, 2'b00, 2'b00, 64'd0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_cnt = '0; m_sel = '0; m_irq = 1'b0;
    idle();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1 during reset");
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    cycle_chk("R1 after release");

    // R2 plain counting
    set_in(1, 0, 2'd3, 0, 0, 2'b00, 2'b00, 64'd0);
    repeat (3) cycle_chk("R2");
    // R3 halt
    set_in(1, 1, 2'd3, 0, 0, 2'b00, 2'b00, 64'd0);
    repeat (2) cycle_chk("R3");

    // R4 machine inhibit
    set_in(0, 0, 2'd3, 0, 0, 2'b00, 2'b01, 64'd1 << 62); cycle_chk("R9 sel write");
    set_in(1, 0, 2'd3, 0, 0, 2'b00, 2'b00, 64'd0); cycle_chk("R4 M blocked");
    set_in(1, 0, 2'd3, 1, 0, 2'b00, 2'b00, 64'd0); cycle_chk("R4 M blocked virt");
    set_in(1, 0, 2'd1, 0, 0, 2'b00, 2'b00, 64'd0); cycle_chk("R4 S counts");
    // S and U plain inhibit
    set_in(0, 0, 2'd3, 0, 0, 2'b00, 2'b01, 64'd1 << 61); cycle_chk("R9 sel write");
    set_in(1, 0, 2'd1, 0, 0, 2'b00, 2'b00, 64'd0); cycle_chk("R4 S blocked");
    set_in(1, 0, 2'd1, 1, 0, 2'b00, 2'b00, 64'd0); cycle_chk("R5 VS ignores S bit");
    set_in(0, 0, 2'd3, 0, 0, 2'b00, 2'b01, 64'd1 << 60); cycle_chk("R9 sel write");
    set_in(1, 0, 2'd0, 0, 0, 2'b00, 2'b00, 64'd0); cycle_chk("R4 U blocked");
    set_in(1, 0, 2'd0, 1, 0, 2'b00, 2'b00, 64'd0); cycle_chk("R5 VU ignores U bit");
    // Virtualized inhibit
    set_in(0, 0, 2'd3, 0, 0, 2'b00, 2'b01, 64'd1 << 59); cycle_chk("R9 sel write");
    set_in(1, 0, 2'd1, 1, 0, 2'b00, 2'b00, 64'd0); cycle_chk("R5 VS blocked");
    set_in(1, 0, 2'd1, 0, 0, 2'b00, 2'b00, 64'd0); cycle_chk("R5 S counts");
    set_in(0, 0, 2'd3, 0, 0, 2'b00, 2'b01, 64'd1 << 58); cycle_chk("R9 sel write");
    set_in(1, 0, 2'd0, 1, 0, 2'b00, 2'b00, 64'd0); cycle_chk("R5 VU blocked");
    // Reserved code never blocked
    set_in(0, 0, 2'd3, 0, 0, 2'b00, 2'b01, 64'h7C00_0000_0000_0000); cycle_chk("R9 sel write");
    set_in(1, 0, 2'd2, 0, 0, 2'b00, 2'b00, 64'd0); cycle_chk("R4 reserved counts");
    set_in(0, 0, 2'd3, 0, 0, 2'b00, 2'b01, 64'd0); cycle_chk("R9 sel clear");

    // R6 carry and wrap
    set_in(0, 0, 2'd3, 0, 0, 2'b01, 2'b00, 64'h0000_0000_FFFF_FFFF); cycle_chk("R9 cnt write");
    set_in(1, 0, 2'd3, 0, 0, 2'b00, 2'b00, 64'd0); cycle_chk("R6 carry");
    set_in(0, 0, 2'd3, 0, 0, 2'b01, 2'b00, '1); cycle_chk("R9 cnt write");
    set_in(1, 0, 2'd3, 0, 0, 2'b00, 2'b00, 64'd0); cycle_chk("R7 first wrap irq");
    idle(); cycle_chk("R7 irq one cycle");
    set_in(0, 0, 2'd3, 0, 0, 2'b01, 2'b00, '1); cycle_chk("R9 cnt write");
    set_in(1, 0, 2'd3, 0, 0, 2'b00, 2'b00, 64'd0); cycle_chk("R7 no irq flag set");
    idle(); repeat (2) cycle_chk("R8 flag sticky");
    set_in(0, 0, 2'd3, 0, 0, 2'b00, 2'b01, 64'd0); cycle_chk("R8 flag cleared");

    // R11 write priority
    set_in(1, 0, 2'd3, 0, 0, 2'b01, 2'b00, 64'd5); cycle_chk("R11 cnt write wins");
    set_in(1, 0, 2'd3, 0, 0, 2'b00, 2'b01, 64'd0); cycle_chk("R11 sel write blocks step");

    // R9 high strobes ignored in wide mode
    set_in(0, 0, 2'd3, 0, 0, 2'b10, 2'b00, 64'h1234_5678_9ABC_DEF0); cycle_chk("R9 high cnt strobe ignored");
    set_in(0, 0, 2'd3, 0, 0, 2'b00, 2'b10, '1); cycle_chk("R9 high sel strobe ignored");

    // R10 narrow mode
    set_in(0, 0, 2'd3, 0, 1, 2'b01, 2'b00, 64'h0000_0000_FFFF_FFFF); cycle_chk("R10 low half");
    set_in(1, 0, 2'd3, 0, 1, 2'b00, 2'b00, 64'd0); cycle_chk("R10 carry in narrow");
    set_in(0, 0, 2'd3, 0, 1, 2'b01, 2'b00, 64'h0000_0000_FFFF_FFFF); cycle_chk("R10 low half");
    set_in(1, 0, 2'd3, 0, 1, 2'b00, 2'b00, 64'd0); cycle_chk("R10 no wrap on low alone");
    set_in(0, 0, 2'd3, 0, 1, 2'b10, 2'b00, 64'h0000_0000_FFFF_FFFF); cycle_chk("R10 high half");
    set_in(0, 0, 2'd3, 0, 1, 2'b01, 2'b00, 64'h0000_0000_FFFF_FFFF); cycle_chk("R10 low half");
    set_in(1, 0, 2'd3, 0, 1, 2'b00, 2'b00, 64'd0); cycle_chk("R10 wrap irq");
    set_in(0, 0, 2'd3, 0, 1, 2'b00, 2'b01, 64'h0000_0000_0000_0000); cycle_chk("R10 low sel strobe ignored");
    set_in(0, 0, 2'd3, 0, 1, 2'b00, 2'b10, 64'h0000_0000_0000_0000); cycle_chk("R10 flag cleared");
    set_in(0, 0, 2'd3, 0, 1, 2'b00, 2'b10, 64'h0000_0000_8000_0000); cycle_chk("R10 flag written");
    set_in(0, 0, 2'd3, 0, 1, 2'b00, 2'b10, 64'h0000_0000_0400_0000); cycle_chk("R10 VU bit written");

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic [63:0] wd;
      case ($urandom % 4)
        0:       wd = {$urandom, $urandom};
        1:       wd = 64'hFFFF_FFFF_FFFF_FFF0 | 64'($urandom % 16);
        2:       wd = 64'h0000_0000_FFFF_FFF0 | 64'($urandom % 16);
        default: wd = 64'($urandom % 4);
      endcase
      set_in(($urandom % 4) != 0, ($urandom % 8) == 0, 2'($urandom), 1'($urandom),
             1'($urandom), (($urandom % 12) == 0) ? 2'($urandom) : 2'b00,
             (($urandom % 12) == 0) ? 2'($urandom) : 2'b00, wd);
      cycle_chk("R2 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule